// File: doc/BRIEF.md
# Tiny 8-bit Microcontroller Subset Core

This block is a small single-issue processor core. It executes a narrow subset of an 8-bit RISC microcontroller instruction set, fetching one 16-bit instruction word per step from a word-addressed instruction memory port with asynchronous read. The core holds thirty-two 8-bit general registers, an 8-bit status register and a program counter. The supported operations are no-operation, register-to-register copy, nibble exchange, load of an 8-bit constant into the upper register half, single status-bit set and clear, and a PC-relative jump. Every other encoding is treated as illegal.

A debug read port selects any general register combinationally, and the status register is always visible. The core raises a one-cycle retire pulse once the effects of each instruction are visible, so a monitor can step alongside it. Illegal words raise a flag together with that pulse. The program counter is an `IMEM_AW`-bit word address, at most 16 bits, and wraps modulo the instruction memory size.

Top module: `tiny8_core`

## Requirements
- R1: While rst_ni is low and right after it is released, imem_addr_o is 0, status_o is 0, every general register reads 0, and retire_o and illegal_o are 0.
- R2: Word 16'h0000 is a no-operation: it changes no register or status bit and advances the PC by one word. Any other word whose bits 15:12 equal 4'h0 is illegal (R9).
- R3: A word with (w & 16'hFC00) == 16'h2C00 copies register {w[9], w[3:0]} into register w[8:4]. Other words whose bits 15:12 equal 4'h2 are illegal.
- R4: A word with (w & 16'hFE0F) == 16'h9402 exchanges the two nibbles of register w[8:4].
- R5: A word with (w & 16'hFF8F) == 16'h9408 sets status bit w[6:4], and a word with (w & 16'hFF8F) == 16'h9488 clears it. Bits 0 to 7 are the C, Z, N, V, S, H, T and I flags, and no other status bit changes. Any other word whose bits 15:12 equal 4'h9 is illegal.
- R6: A word whose bits 15:12 equal 4'hE loads the constant {w[11:8], w[3:0]} into register 16 + w[7:4].
- R7: A word whose bits 15:12 equal 4'hC jumps to (PC + 1 + signed w[11:0]) modulo the memory size, in words.
- R8: Every instruction except the jump retires one clock after the previous retire. A jump retires two clocks after the previous retire. retire_o pulses for one cycle per instruction, with all of its effects visible in that cycle.
- R9: Words whose bits 15:12 are 1, 3 to 8, A, B, D or F, and the illegal words of R2, R3 and R5, assert illegal_o together with retire_o. They leave the registers and the status unchanged and advance the PC by one word.
- R10: imem_addr_o presents the current PC. In imem_rdata_i, bits 7:0 carry the first (lower-address) byte of the instruction and bits 15:8 carry the second byte.
- R11: Sequential advance from the last word of instruction memory wraps to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | IMEM_AW | Instruction word address (the PC) |
| imem_rdata_i | input | 16 | Instruction word: first byte in bits 7:0, second byte in bits 15:8 |
| dbg_sel_i | input | 5 | Debug register select |
| dbg_reg_o | output | 8 | Contents of the selected register |
| status_o | output | 8 | Status register (bit 0 C through bit 7 I) |
| retire_o | output | 1 | One-cycle pulse per completed instruction |
| illegal_o | output | 1 | Pulse with retire_o when the instruction was illegal |

## Verification
The bench builds the core with IMEM_AW = 6, so the instruction memory holds only 64 words. Sequential execution therefore runs off the top and wraps to 0 within a short program, and most random 12-bit jump offsets wrap the target around the memory in both directions. A directed program covers all sixteen flag operations, forward and backward jumps and several illegal words. Random words drawn from every encoding class then follow, and the register file, status, PC, illegal flag and retire spacing are compared after each retire.

// File: rtl/tiny8_pkg.sv
`timescale 1ns/1ps
package tiny8_pkg;
  localparam int unsigned NREG  = 32;
  localparam int unsigned DW    = 8;
  localparam int unsigned RAW   = $clog2(NREG);
  localparam int unsigned IW    = 16;
  localparam int unsigned OFF_W = 12;
  localparam int unsigned PC_W  = 16;

  typedef enum logic [2:0] {
    OP_NOP, OP_MOV, OP_SWAP, OP_FSET, OP_FCLR, OP_LDI, OP_JMP, OP_ILL
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [RAW-1:0]   rd;
    logic [RAW-1:0]   rs;
    logic [2:0]       fidx;
    logic [DW-1:0]    imm;
    logic [OFF_W-1:0] off;
  } dec_t;
endpackage

// File: rtl/tiny8_decode.sv
`timescale 1ns/1ps
module tiny8_decode
  import tiny8_pkg::*;
(
  input  logic [IW-1:0] word_i,
  output dec_t          dec_o
);
  always_comb begin
    dec_o      = '0;
    dec_o.op   = OP_ILL;
    dec_o.rd   = word_i[8:4];
    dec_o.rs   = {word_i[9], word_i[3:0]};
    dec_o.fidx = word_i[6:4];
    dec_o.imm  = {word_i[11:8], word_i[3:0]};
    dec_o.off  = word_i[11:0];
    unique case (word_i[15:12])
      4'h0: if (word_i == 16'h0000) dec_o.op = OP_NOP;
      4'h2: if ((word_i & 16'hFC00) == 16'h2C00) dec_o.op = OP_MOV;
      4'h9: begin
        if ((word_i & 16'hFE0F) == 16'h9402) begin
          dec_o.op = OP_SWAP;
          dec_o.rs = word_i[8:4];   // swap reads its own destination
        end else if ((word_i & 16'hFF8F) == 16'h9408) begin
          dec_o.op = OP_FSET;
        end else if ((word_i & 16'hFF8F) == 16'h9488) begin
          dec_o.op = OP_FCLR;
        end
      end
      4'hC: dec_o.op = OP_JMP;
      4'hE: begin
        dec_o.op = OP_LDI;
        dec_o.rd = {1'b1, word_i[7:4]};
      end
      default: dec_o.op = OP_ILL;
    endcase
  end
endmodule

// File: rtl/tiny8_regfile.sv
`timescale 1ns/1ps
module tiny8_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned DW   = 8,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  input  logic [AW-1:0] dbg_addr_i,
  output logic [DW-1:0] dbg_data_o
);
  logic [NREG-1:0][DW-1:0] regs_w;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             r_q <= '0;
      else if (we_i && waddr_i == AW'(g))      r_q <= wdata_i;
    end
    assign regs_w[g] = r_q;
  end

  assign rdata_o    = regs_w[raddr_i];
  assign dbg_data_o = regs_w[dbg_addr_i];

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_w[$past(waddr_i)] == $past(wdata_i)); // R6
endmodule

// File: rtl/tiny8_status.sv
`timescale 1ns/1ps
module tiny8_status #(
  parameter int unsigned SW  = 8,
  localparam int unsigned IXW = $clog2(SW)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           set_i,
  input  logic           clr_i,
  input  logic [IXW-1:0] idx_i,
  output logic [SW-1:0]  st_o
);
  logic [SW-1:0] st_q;

  for (genvar b = 0; b < SW; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[b] <= 1'b0;
      else if (idx_i == IXW'(b)) begin
        if (set_i)      st_q[b] <= 1'b1;
        else if (clr_i) st_q[b] <= 1'b0;
      end
    end
  end

  assign st_o = st_q;

  AST_ONE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(st_q ^ $past(st_q)) <= 1); // R5
  AST_SET_HITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> st_q[$past(idx_i)]); // R5
endmodule

// File: rtl/tiny8_core.sv
`timescale 1ns/1ps
module tiny8_core
  import tiny8_pkg::*;
#(
  parameter int unsigned IMEM_AW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [IMEM_AW-1:0] imem_addr_o,
  input  logic [IW-1:0]      imem_rdata_i,
  input  logic [RAW-1:0]     dbg_sel_i,
  output logic [DW-1:0]      dbg_reg_o,
  output logic [DW-1:0]      status_o,
  output logic               retire_o,
  output logic               illegal_o
);
  dec_t               dec;
  logic [IMEM_AW-1:0] pc_q, tgt_q, pc_inc, tgt;
  logic               jmp_q, retire_q, illegal_q, exec;
  logic               rf_we;
  logic [DW-1:0]      rf_wdata, rs_data;

  tiny8_decode u_dec (.word_i(imem_rdata_i), .dec_o(dec));

  assign exec   = !jmp_q;
  assign pc_inc = pc_q + 1'b1;
  // sign-extend the 12-bit word offset and wrap to memory size
  assign tgt    = pc_inc + IMEM_AW'({{(PC_W-OFF_W){dec.off[OFF_W-1]}}, dec.off});

  assign rf_we = exec && (dec.op inside {OP_MOV, OP_SWAP, OP_LDI});
  always_comb begin
    unique case (dec.op)
      OP_SWAP: rf_wdata = {rs_data[3:0], rs_data[7:4]};
      OP_LDI:  rf_wdata = dec.imm;
      default: rf_wdata = rs_data;
    endcase
  end

  tiny8_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk_i, .rst_ni,
    .we_i(rf_we), .waddr_i(dec.rd), .wdata_i(rf_wdata),
    .raddr_i(dec.rs), .rdata_o(rs_data),
    .dbg_addr_i(dbg_sel_i), .dbg_data_o(dbg_reg_o)
  );

  tiny8_status #(.SW(DW)) u_st (
    .clk_i, .rst_ni,
    .set_i(exec && dec.op == OP_FSET),
    .clr_i(exec && dec.op == OP_FCLR),
    .idx_i(dec.fidx),
    .st_o(status_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q      <= '0;
      tgt_q     <= '0;
      jmp_q     <= 1'b0;
      retire_q  <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      retire_q  <= 1'b0;
      illegal_q <= 1'b0;
      if (jmp_q) begin
        pc_q     <= tgt_q;
        jmp_q    <= 1'b0;
        retire_q <= 1'b1;
      end else if (dec.op == OP_JMP) begin
        jmp_q <= 1'b1;
        tgt_q <= tgt;
      end else begin
        pc_q      <= pc_inc;
        retire_q  <= 1'b1;
        illegal_q <= (dec.op == OP_ILL);
      end
    end
  end

  assign imem_addr_o = pc_q;
  assign retire_o    = retire_q;
  assign illegal_o   = illegal_q;

  AST_JMP_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && dec.op == OP_JMP) |=> (jmp_q && !retire_o)); // R8
  AST_JMP_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jmp_q |=> (!jmp_q && retire_o)); // R8
  AST_PC_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && dec.op != OP_JMP) |=> imem_addr_o == IMEM_AW'($past(imem_addr_o) + 1'b1)); // R11
  AST_ILL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && dec.op == OP_ILL) |=> ($stable(status_o) && illegal_o)); // R9
  AST_ILL_RETIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> retire_o); // R9
endmodule

// File: tb/tiny8_core_bench.sv
`timescale 1ns/1ps
module tiny8_core_bench;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] imem_addr_o;
  logic [15:0]   imem_rdata_i;
  logic [4:0]    dbg_sel = '0;
  logic [7:0]    dbg_reg_o, status_o;
  logic          retire_o, illegal_o;

  logic [7:0] bmem [2*DEPTH];
  logic [7:0] m_regs [32];
  logic [7:0] m_st;
  int         m_pc;
  int         compared = 0, mismatched = 0, cycles = 0;
  bit         hung = 0;

  always #2.5 clk_i = ~clk_i;

  // first byte is the low half of the word
  assign imem_rdata_i = {bmem[2*imem_addr_o+1], bmem[2*imem_addr_o]};

  tiny8_core #(.IMEM_AW(AW)) u_tiny8_core (
    .clk_i, .rst_ni, .imem_addr_o, .imem_rdata_i,
    .dbg_sel_i(dbg_sel), .dbg_reg_o, .status_o, .retire_o, .illegal_o
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] e_ldi(int d, int k);
    return 16'hE000 | 16'((k & 8'hF0) << 4) | 16'(((d - 16) & 15) << 4) | 16'(k & 15);
  endfunction
  function automatic logic [15:0] e_mov(int d, int r);
    return 16'h2C00 | 16'(((r >> 4) & 1) << 9) | 16'((d & 31) << 4) | 16'(r & 15);
  endfunction
  function automatic logic [15:0] e_swap(int d);
    return 16'h9402 | 16'((d & 31) << 4);
  endfunction
  function automatic logic [15:0] e_fset(int b);
    return 16'h9408 | 16'((b & 7) << 4);
  endfunction
  function automatic logic [15:0] e_fclr(int b);
    return 16'h9488 | 16'((b & 7) << 4);
  endfunction
  function automatic logic [15:0] e_jmp(int off);
    return 16'hC000 | 16'(off & 12'hFFF);
  endfunction

  task automatic put(int a, logic [15:0] w);
    bmem[2*a]   = w[7:0];
    bmem[2*a+1] = w[15:8];
  endtask

  task automatic model_step(input logic [15:0] w, output bit is_j, output bit is_ill,
                            output string tag);
    int off;
    is_j = 0; is_ill = 0; tag = "R2";
    case (w[15:12])
      4'h0: if (w != 16'h0000) is_ill = 1;
      4'h2: if ((w & 16'hFC00) == 16'h2C00) begin
              m_regs[w[8:4]] = m_regs[{w[9], w[3:0]}]; tag = "R3";
            end else is_ill = 1;
      4'h9: if ((w & 16'hFE0F) == 16'h9402) begin
              m_regs[w[8:4]] = {m_regs[w[8:4]][3:0], m_regs[w[8:4]][7:4]}; tag = "R4";
            end else if ((w & 16'hFF8F) == 16'h9408) begin
              m_st[w[6:4]] = 1'b1; tag = "R5";
            end else if ((w & 16'hFF8F) == 16'h9488) begin
              m_st[w[6:4]] = 1'b0; tag = "R5";
            end else is_ill = 1;
      4'hC: begin
              is_j = 1; tag = "R7";
              off = int'($signed(w[11:0]));
              m_pc = (m_pc + 1 + off) & (DEPTH - 1);
            end
      4'hE: begin m_regs[{1'b1, w[7:4]}] = {w[11:8], w[3:0]}; tag = "R6"; end
      default: is_ill = 1;
    endcase
    if (is_ill) tag = "R9";
    if (!is_j) m_pc = (m_pc + 1) & (DEPTH - 1);
  endtask

  task automatic sweep_regs(input string tag);
    for (int i = 0; i < 32; i++) begin
      dbg_sel = 5'(i);
      #0.04;
      chk(tag, $sformatf("r%0d", i), int'(dbg_reg_o), int'(m_regs[i]));
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < 32; i++) m_regs[i] = '0;
    m_st = '0; m_pc = 0;
    repeat (2) @(negedge clk_i);
    chk("R1", "pc", int'(imem_addr_o), 0);
    chk("R1", "status", int'(status_o), 0);
    chk("R1", "retire", int'(retire_o), 0);
    chk("R1", "illegal", int'(illegal_o), 0);
    sweep_regs("R1");
    rst_ni = 1'b1;
  endtask

  task automatic run(input int n, input bit first_tag);
    int gap = 0, done = 0;
    while (done < n && !hung) begin
      logic [15:0] w;
      bit j, ill, wrap;
      string tag;
      @(negedge clk_i);
      gap++; cycles++;
      if (gap > 4 || cycles > 50000) begin
        hung = 1;
        chk("R8", "watchdog expired", 1, 0);
      end else if (retire_o) begin
        w = {bmem[2*m_pc+1], bmem[2*m_pc]};
        wrap = (m_pc == DEPTH - 1);
        model_step(w, j, ill, tag);
        if (first_tag && done == 0) tag = "R10";
        chk("R8", "retire gap", gap, j ? 2 : 1);
        chk("R9", "illegal_o", int'(illegal_o), int'(ill));
        chk((wrap && !j) ? "R11" : tag, "pc", int'(imem_addr_o), m_pc);
        chk(tag, "status", int'(status_o), int'(m_st));
        sweep_regs(tag);
        gap = 0; done++;
      end else begin
        chk("R9", "illegal_o idle", int'(illegal_o), 0);
      end
    end
  endtask

  function automatic logic [15:0] rand_word();
    case ($urandom_range(0, 7))
      0: return 16'h0000;
      1: return e_mov($urandom_range(0, 31), $urandom_range(0, 31));
      2: return e_swap($urandom_range(0, 31));
      3: return e_fset($urandom_range(0, 7));
      4: return e_fclr($urandom_range(0, 7));
      5: return e_ldi($urandom_range(16, 31), $urandom_range(0, 255));
      6: return e_jmp($urandom_range(0, 4095));
      default: return 16'($urandom());
    endcase
  endfunction

  initial begin
    void'($urandom(32'd7331));
    for (int a = 0; a < DEPTH; a++) put(a, 16'h0000);
    // directed program
    put(0, e_ldi(31, 8'h3C));
    put(1, e_ldi(16, 8'hA5));
    put(2, e_mov(0, 16));
    put(3, e_mov(17, 31));
    put(4, e_swap(0));
    for (int b = 0; b < 8; b++) put(5 + b, e_fset(b));
    for (int b = 0; b < 8; b++) put(13 + b, e_fclr(b));
    put(21, 16'h0000);
    put(22, 16'h0001);
    put(23, 16'h2800);
    put(24, 16'h9400);
    put(25, 16'h1234);
    put(26, 16'h9409);
    put(27, e_jmp(3));        // forward to 31
    for (int a = 28; a < 31; a++) put(a, e_ldi(20, 8'hFF));
    put(31, e_ldi(21, 8'h11));
    put(32, e_jmp(7));        // forward to 40
    put(33, e_ldi(22, 8'h77));
    put(34, e_jmp(15));       // forward to 50
    put(40, e_fset(2));
    put(41, e_jmp(-9));       // backward to 33
    put(62, 16'hF00F);
    do_reset();
    run(150, 1'b1);
    // random program after a reset from non-zero state
    for (int a = 0; a < DEPTH; a++) put(a, rand_word());
    do_reset();
    run(3000, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule